// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Comparator

This unit sits next to a CPU core and watches two buses at once: the instruction-fetch address with its valid strobe, and the data-memory address with its read and write strobes. A debug host programs one control register and two address registers through a small register port. When an access that the host has qualified hits a programmed address, the unit latches a pending flag for that address and raises a halt request toward the CPU.

Each of the two address registers acts as its own breakpoint or watchpoint in exact mode. With range mode on, the pair instead bounds a single inclusive window. A hit anywhere in that window is reported on flag 0. The trigger can be any mix of the fetch, data-read and data-write qualifiers. A build-time parameter removes the range comparators altogether.

Pending flags are sticky. The halt request stays high until the host clears every set flag by writing ones to the status register. Register map on `cfg_sel`: 0 = control, 1 = address 0, 2 = address 1, 3 = status.

Top module: `hwbrk_unit`

## Requirements
- R1: After reset the control register, both address registers, the status flags and `halt_req` all read as zero.
- R2: Control bits: bit 0 qualifies data reads, bit 1 qualifies data writes, bit 3 qualifies instruction fetches and bit 2 enables the unit. Control reads back bits [4:0] as written, and bits [15:5] read as zero. An access whose qualifier bit is clear never sets a flag.
- R3: While control bit 2 is clear, no access of any kind sets a flag.
- R4: In exact mode, a qualified access whose address equals address register i sets flag i (status bit i, `hit_flags[i]`) on the next clock edge. If both registers hold that address, both flags set. An access one address off sets nothing.
- R5: With control bit 4 set, a qualified access with address0 <= addr <= address1 sets flag 0 and leaves flag 1 alone. Addresses just outside the window set nothing. If address0 > address1, nothing matches.
- R6: With the range parameter off, control bit 4 reads as zero and has no effect, so matching stays exact.
- R7: Flags are sticky. Writing status clears each flag whose write-data bit is 1 and leaves the flags under 0 bits unchanged. `halt_req` is high exactly while any flag is set.
- R8: If a new hit on a flag and a host clear of that same flag occur in one cycle, the flag stays set.
- R9: Each address register reads back the full 16-bit value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel | input | 2 | Register select: 0 control, 1 address 0, 2 address 1, 3 status |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| fetch_addr | input | 16 | Instruction-fetch address |
| fetch_vld | input | 1 | Instruction-fetch strobe |
| data_addr | input | 16 | Data-memory address |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| hit_flags | output | 2 | Sticky pending flags, one per address register |
| halt_req | output | 1 | Halt request to the CPU |

## Verification
A fresh hit and the host's write-one clear of the same flag can land on the same clock edge. The bench provokes this by first latching flag 0 with a fetch inside the range. The following cycle then drives another in-window fetch together with a status write of 1 to bit 0. The expected result is that the flag and the halt request stay high after that edge. A plain clear on the next cycle must then drop both.

// File: rtl/hwbrk_pkg.sv
package hwbrk_pkg;

  localparam int NPT    = 2;   // address registers per unit
  localparam int CTRL_W = 5;   // implemented control bits

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR0 = 2'd1,
    SEL_ADDR1 = 2'd2,
    SEL_STAT  = 2'd3
  } sel_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic range_mode;
    logic fetch_en;
    logic unit_en;
    logic wr_en;
    logic rd_en;
  } ctrl_t;

endpackage

// File: rtl/hwbrk_regs.sv
module hwbrk_regs
  import hwbrk_pkg::*;
#(
  parameter int AW       = 16,
  parameter bit RANGE_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_sel,
  input  logic                    cfg_wr,
  input  logic [AW-1:0]           cfg_wdata,
  input  logic [NPT-1:0]          flags,
  output ctrl_t                   ctrl,
  output logic [NPT-1:0][AW-1:0]  addr,
  output logic [AW-1:0]           cfg_rdata
);

  sel_e  sel;
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_ld;

  assign sel = sel_e'(cfg_sel);

  // control register: next state
  assign ctrl_ld = cfg_wr && (sel == SEL_CTRL);

  always_comb begin
    ctrl_d = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    if (!RANGE_EN) ctrl_d.range_mode = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ld) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // address registers, one per comparator
  for (genvar i = 0; i < NPT; i++) begin : g_addr
    logic          a_ld;
    logic [AW-1:0] a_q;

    assign a_ld = cfg_wr && (cfg_sel == 2'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    a_q <= '0;
      else if (a_ld) a_q <= cfg_wdata;
    end

    assign addr[i] = a_q;
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_CTRL:  cfg_rdata = {{(AW-CTRL_W){1'b0}}, ctrl_q};
      SEL_ADDR0: cfg_rdata = addr[0];
      SEL_ADDR1: cfg_rdata = addr[1];
      default:   cfg_rdata = {{(AW-NPT){1'b0}}, flags};
    endcase
  end

endmodule

// File: rtl/hwbrk_match.sv
module hwbrk_match
  import hwbrk_pkg::*;
#(
  parameter int AW       = 16,
  parameter bit RANGE_EN = 1'b1
) (
  input  ctrl_t                   ctrl,
  input  logic [NPT-1:0][AW-1:0]  addr,
  input  logic [AW-1:0]           fetch_addr,
  input  logic                    fetch_vld,
  input  logic [AW-1:0]           data_addr,
  input  logic                    data_rd,
  input  logic                    data_wr,
  output logic [NPT-1:0]          hit
);

  logic           f_qual, d_qual;
  logic [NPT-1:0] exact;
  logic           rng_hit;
  logic           use_rng;

  assign f_qual = ctrl.fetch_en & fetch_vld;
  assign d_qual = (ctrl.rd_en & data_rd) | (ctrl.wr_en & data_wr);

  // equality comparators, one pair per address register
  for (genvar i = 0; i < NPT; i++) begin : g_eq
    logic f_eq, d_eq;
    assign f_eq     = (fetch_addr == addr[i]);
    assign d_eq     = (data_addr  == addr[i]);
    assign exact[i] = (f_qual & f_eq) | (d_qual & d_eq);
  end

  // window comparators, only when the build keeps range mode
  if (RANGE_EN) begin : g_rng
    logic f_in, d_in;
    assign f_in    = (fetch_addr >= addr[0]) && (fetch_addr <= addr[1]);
    assign d_in    = (data_addr  >= addr[0]) && (data_addr  <= addr[1]);
    assign rng_hit = (f_qual & f_in) | (d_qual & d_in);
    assign use_rng = ctrl.range_mode;
  end else begin : g_norng
    assign rng_hit = 1'b0;
    assign use_rng = ctrl.range_mode & 1'b0;
  end

  always_comb begin
    hit = '0;
    if (ctrl.unit_en) begin
      if (use_rng) hit[0] = rng_hit;
      else         hit    = exact;
    end
  end

endmodule

// File: rtl/hwbrk_status.sv
module hwbrk_status
  import hwbrk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPT-1:0] set,
  input  logic           clr_vld,
  input  logic [NPT-1:0] clr_mask,
  output logic [NPT-1:0] flags
);

  logic [NPT-1:0] flags_q, flags_d, clr_eff;
  logic           flags_ld;

  assign clr_eff  = clr_vld ? clr_mask : '0;
  // a fresh hit outranks a clear of the same bit
  assign flags_d  = (flags_q & ~clr_eff) | set;
  assign flags_ld = (|set) | clr_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_ld) flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/hwbrk_unit.sv
module hwbrk_unit
  import hwbrk_pkg::*;
#(
  parameter int AW       = 16,
  parameter bit RANGE_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_sel,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_vld,
  input  logic [AW-1:0] data_addr,
  input  logic          data_rd,
  input  logic          data_wr,
  output logic [1:0]    hit_flags,
  output logic          halt_req
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ctrl_t                  ctrl;
  logic [NPT-1:0][AW-1:0] addr;
  logic [NPT-1:0]         hit_raw;
  logic [NPT-1:0]         flags;
  logic                   unit_en;
  logic                   stat_wr;

  assign unit_en = ctrl.unit_en;
  assign stat_wr = cfg_wr && (cfg_sel == SEL_STAT);

  hwbrk_regs #(.AW(AW), .RANGE_EN(RANGE_EN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .flags     (flags),
    .ctrl      (ctrl),
    .addr      (addr),
    .cfg_rdata (cfg_rdata)
  );

  hwbrk_match #(.AW(AW), .RANGE_EN(RANGE_EN)) u_match (
    .ctrl       (ctrl),
    .addr       (addr),
    .fetch_addr (fetch_addr),
    .fetch_vld  (fetch_vld),
    .data_addr  (data_addr),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .hit        (hit_raw)
  );

  hwbrk_status u_stat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set      (hit_raw),
    .clr_vld  (stat_wr),
    .clr_mask (cfg_wdata[NPT-1:0]),
    .flags    (flags)
  );

  assign hit_flags = flags;
  assign halt_req  = |flags;

endmodule

// File: rtl/hwbrk_unit_chk.sv
module hwbrk_unit_chk #(
  parameter int AW       = 16,
  parameter bit RANGE_EN = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_sel,
  input logic          cfg_wr,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] cfg_rdata,
  input logic          unit_en,
  input logic [1:0]    hit_raw,
  input logic [1:0]    hit_flags,
  input logic          halt_req
);

  for (genvar i = 0; i < 2; i++) begin : g_bit
    // R7: a flag only drops after a host write of 1 to its status bit
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_flags[i] && !(cfg_wr && cfg_sel == 2'd3 && cfg_wdata[i]) |=> hit_flags[i]);

    // R8: a comparator hit always lands, even against a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_raw[i] |=> hit_flags[i]);

    // R4: a flag never rises without a comparator hit
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_flags[i] && !hit_raw[i] |=> !hit_flags[i]);
  end

  // R3: a disabled unit produces no comparator hits
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |-> hit_raw == 2'b00);

  // R7: the halt request only rises after a hit
  assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(hit_raw != 2'b00));

  if (!RANGE_EN) begin : g_norng
    // R6: range bit reads as zero when range mode is built out
    assert_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel == 2'd0 |-> !cfg_rdata[4]);
  end

endmodule

bind hwbrk_unit hwbrk_unit_chk #(.AW(AW), .RANGE_EN(RANGE_EN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .unit_en   (unit_en),
  .hit_raw   (hit_raw),
  .hit_flags (hit_flags),
  .halt_req  (halt_req)
);

// File: tb/tb_hwbrk_unit.sv
`timescale 1ns/1ps
module tb_hwbrk_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_sel;
  logic        cfg_wr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [15:0] fetch_addr, data_addr;
  logic        fetch_vld, data_rd, data_wr;
  logic [1:0]  hit_flags;
  logic        halt_req;

  // second instance built without range mode
  logic [1:0]  nr_sel;
  logic        nr_wr;
  logic [15:0] nr_wdata, nr_rdata, nr_faddr;
  logic        nr_fvld;
  logic [1:0]  nr_flags;
  logic        nr_halt;

  always #4 clk = ~clk;  // 125 MHz

  hwbrk_unit #(.AW(16), .RANGE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
    .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
    .hit_flags(hit_flags), .halt_req(halt_req)
  );

  hwbrk_unit #(.AW(16), .RANGE_EN(1'b0)) dut_nr (
    .clk(clk), .rst_n(rst_n), .cfg_sel(nr_sel), .cfg_wr(nr_wr),
    .cfg_wdata(nr_wdata), .cfg_rdata(nr_rdata),
    .fetch_addr(nr_faddr), .fetch_vld(nr_fvld),
    .data_addr(16'h0000), .data_rd(1'b0), .data_wr(1'b0),
    .hit_flags(nr_flags), .halt_req(nr_halt)
  );

  typedef struct {
    logic [1:0]  fl;
    logic        rdchk;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares one expected item per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "hit_flags", {14'b0, hit_flags}, {14'b0, e.fl});
        chk(e.tag, "halt_req",  {15'b0, halt_req},  {15'b0, |e.fl});
        if (e.rdchk) chk(e.tag, "cfg_rdata", cfg_rdata, e.rd);
      end
    end
  end

  // driver: one bus cycle, expectation for the state after the next edge
  task automatic step(input logic [1:0] sel, input logic wr, input logic [15:0] wd,
                      input logic [15:0] fa, input logic fv,
                      input logic [15:0] da, input logic dr, input logic dw,
                      input logic rc, input logic [15:0] rd,
                      input logic [1:0] fl, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_sel = sel; cfg_wr = wr; cfg_wdata = wd;
    fetch_addr = fa; fetch_vld = fv;
    data_addr = da; data_rd = dr; data_wr = dw;
    e.fl = fl; e.rdchk = rc; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [15:0] d,
                      input logic [1:0] fl, input string tag);
    step(s, 1'b1, d, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, fl, tag);
  endtask
  task automatic rreg(input logic [1:0] s, input logic [15:0] x,
                      input logic [1:0] fl, input string tag);
    step(s, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, x, fl, tag);
  endtask
  task automatic fet(input logic [15:0] a, input logic [1:0] fl, input string tag);
    step(2'd0, 1'b0, 16'h0, a, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, fl, tag);
  endtask
  task automatic drd(input logic [15:0] a, input logic [1:0] fl, input string tag);
    step(2'd0, 1'b0, 16'h0, 16'h0, 1'b0, a, 1'b1, 1'b0, 1'b0, 16'h0, fl, tag);
  endtask
  task automatic dwr(input logic [15:0] a, input logic [1:0] fl, input string tag);
    step(2'd0, 1'b0, 16'h0, 16'h0, 1'b0, a, 1'b0, 1'b1, 1'b0, 16'h0, fl, tag);
  endtask
  task automatic nop(input logic [1:0] fl, input string tag);
    step(2'd0, 1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0, fl, tag);
  endtask

  task automatic nr_step(input logic [1:0] s, input logic w, input logic [15:0] d,
                         input logic [15:0] fa, input logic fv);
    @(negedge clk);
    nr_sel = s; nr_wr = w; nr_wdata = d; nr_faddr = fa; nr_fvld = fv;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_sel = 2'd0; cfg_wr = 1'b0; cfg_wdata = 16'h0;
    fetch_addr = 16'h0; fetch_vld = 1'b0;
    data_addr = 16'h0; data_rd = 1'b0; data_wr = 1'b0;
    nr_sel = 2'd0; nr_wr = 1'b0; nr_wdata = 16'h0; nr_faddr = 16'h0; nr_fvld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rreg(2'd0, 16'h0000, 2'b00, "R1");
    rreg(2'd1, 16'h0000, 2'b00, "R1");
    rreg(2'd2, 16'h0000, 2'b00, "R1");
    rreg(2'd3, 16'h0000, 2'b00, "R1");

    // R9 address readback
    wreg(2'd1, 16'h1234, 2'b00, "R9");
    wreg(2'd2, 16'h2000, 2'b00, "R9");
    rreg(2'd1, 16'h1234, 2'b00, "R9");
    rreg(2'd2, 16'h2000, 2'b00, "R9");

    // R2 control readback: only bits [4:0] kept; 0x0C = enable + fetch
    wreg(2'd0, 16'hFFEC, 2'b00, "R2");
    rreg(2'd0, 16'h000C, 2'b00, "R2");

    // R4 fetch qualifier, off-by-one and data accesses ignored
    fet(16'h1235, 2'b00, "R4");
    drd(16'h1234, 2'b00, "R4");
    dwr(16'h1234, 2'b00, "R4");
    fet(16'h1234, 2'b01, "R4");

    // R7 sticky, write-0 keeps, write-1 clears
    nop(2'b01, "R7");
    wreg(2'd3, 16'h0002, 2'b01, "R7");
    wreg(2'd3, 16'h0000, 2'b01, "R7");
    rreg(2'd3, 16'h0001, 2'b01, "R7");
    wreg(2'd3, 16'h0001, 2'b00, "R7");

    // R2 read qualifier only (0x05)
    wreg(2'd0, 16'h0005, 2'b00, "R2");
    fet(16'h2000, 2'b00, "R2");
    dwr(16'h2000, 2'b00, "R2");
    drd(16'h2000, 2'b10, "R4");
    wreg(2'd3, 16'h0002, 2'b00, "R7");

    // R2 write qualifier only (0x06)
    wreg(2'd0, 16'h0006, 2'b00, "R2");
    drd(16'h2000, 2'b00, "R2");
    dwr(16'h2000, 2'b10, "R4");
    wreg(2'd3, 16'h0002, 2'b00, "R7");

    // R3 all qualifiers but unit disabled (0x0B)
    wreg(2'd0, 16'h000B, 2'b00, "R3");
    fet(16'h1234, 2'b00, "R3");
    drd(16'h2000, 2'b00, "R3");
    dwr(16'h1234, 2'b00, "R3");

    // R4 both registers on one address
    wreg(2'd2, 16'h1234, 2'b00, "R4");
    wreg(2'd0, 16'h000C, 2'b00, "R4");
    fet(16'h1234, 2'b11, "R4");
    wreg(2'd3, 16'h0003, 2'b00, "R7");

    // R5 range 0x1000..0x10FF, control 0x1D = range+fetch+enable+read
    wreg(2'd1, 16'h1000, 2'b00, "R5");
    wreg(2'd2, 16'h10FF, 2'b00, "R5");
    wreg(2'd0, 16'h001D, 2'b00, "R5");
    rreg(2'd0, 16'h001D, 2'b00, "R5");
    fet(16'h0FFF, 2'b00, "R5");
    fet(16'h1100, 2'b00, "R5");
    fet(16'h1000, 2'b01, "R5");
    wreg(2'd3, 16'h0001, 2'b00, "R5");
    drd(16'h10FF, 2'b01, "R5");
    wreg(2'd3, 16'h0001, 2'b00, "R5");
    fet(16'h1080, 2'b01, "R5");
    wreg(2'd3, 16'h0001, 2'b00, "R5");
    dwr(16'h1080, 2'b00, "R5");

    // R8 hit and clear in the same cycle
    fet(16'h1080, 2'b01, "R8");
    step(2'd3, 1'b1, 16'h0001, 16'h1080, 1'b1, 16'h0, 1'b0, 1'b0,
         1'b0, 16'h0, 2'b01, "R8");
    wreg(2'd3, 16'h0001, 2'b00, "R8");

    // R5 inverted bounds match nothing
    wreg(2'd1, 16'h2000, 2'b00, "R5");
    wreg(2'd2, 16'h1000, 2'b00, "R5");
    fet(16'h1800, 2'b00, "R5");
    fet(16'h2000, 2'b00, "R5");
    fet(16'h1000, 2'b00, "R5");
    nop(2'b00, "R5");

    repeat (2) @(negedge clk);

    // R6 build without range: bit 4 dropped, matching stays exact
    nr_step(2'd0, 1'b1, 16'h001D, 16'h0, 1'b0);
    nr_step(2'd0, 1'b0, 16'h0000, 16'h0, 1'b0);
    chk("R6", "ctrl readback", nr_rdata, 16'h000D);
    nr_step(2'd1, 1'b1, 16'h1000, 16'h0, 1'b0);
    nr_step(2'd2, 1'b1, 16'h10FF, 16'h0, 1'b0);
    nr_step(2'd0, 1'b0, 16'h0000, 16'h1080, 1'b1);
    chk("R6", "flags inside window", {14'b0, nr_flags}, 16'h0000);
    nr_step(2'd0, 1'b0, 16'h0000, 16'h1000, 1'b1);
    chk("R6", "flags exact hit", {14'b0, nr_flags}, 16'h0001);
    chk("R6", "halt", {15'b0, nr_halt}, 16'h0001);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule